// File: doc/BRIEF.md
# Planar Video RAM Write Unit

This block sits between a CPU byte-write port and a video memory split into bit-planes. Every plane stores one bit of each pixel, so one byte address covers eight neighbouring pixels, and a single CPU write acts on all planes in the same operation. Two write-only configuration registers shape each write. The control register holds a drawing-mode bit and a page-size field. The colour register holds either a colour index or a plane mask.

In transparent drawing each set bit of the CPU byte paints its pixel with the colour index. Each clear bit leaves the pixel alone in every plane. To do this the block first reads the old plane bytes and then writes the merged bytes back. In direct drawing the CPU byte is copied unchanged into every plane that the mask selects, and no read is needed. The plane memory outside the block is a plain synchronous RAM with one cycle of read latency and a write enable per plane. The number of planes is a parameter from 1 to 8. With one plane the block acts as a monochrome byte store.

Top module: `planar_wr_unit`

## Requirements
- R1: After reset `wr_ready` is 1 and `mem_re` and `mem_we` are 0. Both registers reset to 0, so the first write is transparent with colour 0 in the 8 kB page.
- R2: Transparent drawing is selected when control bit 4 is 0. Plane p is written as (old & ~data) | (data & {8{ci[p]}}), where old comes from a read of the same address one cycle earlier.
- R3: Direct drawing is selected when control bit 4 is 1. The data byte goes to every plane p with ci[p]=1, and `mem_we[p]` is 0 for every other plane, so those planes are untouched.
- R4: The address sent to memory is `wr_addr` masked to the page size chosen by control bits 1:0. The values 0, 1, 2 and 3 keep the low 13, 14, 15 and 16 address bits.
- R5: A request is accepted when `wr_valid` and `wr_ready` are both 1. `wr_ready` then stays 0 for 2 cycles in transparent drawing (read, then write) and for 1 cycle in direct drawing (write only).
- R6: `cfg_sel`=0 writes the control register and `cfg_sel`=1 writes the colour register. Register values are captured when a request is accepted, so a register write during a busy period affects only later requests.
- R7: A transparent write of data 0x00 leaves all planes unchanged. A write of 0xFF sets all eight pixels to the colour index.
- R8: A direct write with an all-zero mask changes no plane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 = control register, 1 = colour register |
| cfg_wdata | input | 8 | Register write data |
| wr_valid | input | 1 | CPU write request |
| wr_ready | output | 1 | Block idle, request can be accepted |
| wr_addr | input | AW | CPU byte address |
| wr_data | input | 8 | CPU data byte, one bit per pixel |
| mem_re | output | 1 | Plane memory read strobe |
| mem_we | output | NPLANES | Per-plane write enable |
| mem_addr | output | AW | Plane memory address, masked to the page |
| mem_wdata | output | 8*NPLANES | Plane bytes to write, plane p in bits 8p+7:8p |
| mem_rdata | input | 8*NPLANES | Plane bytes read, valid the cycle after `mem_re` |

## Verification
The bench covers several distinct colour patterns:
- A colour index with mixed plane bits. A design that filled every plane with the same bit would get these wrong.
- Data bytes of 0x00 and 0xFF. A design that ignored the data mask would overwrite background pixels or miss some.
- A direct write with a zero mask. A design that did not gate `mem_we` by the mask would corrupt every plane.

It also changes the colour register while a request is in flight. A design that read the live register would paint the wrong colour. Aliased addresses in three page sizes show whether the upper address bits are masked. The ready timing is counted cycle by cycle, which exposes a design that skips the read or holds ready low too long.

// File: rtl/planar_wr_unit.sv
module planar_wr_unit #(
  parameter int NPLANES = 8,
  parameter int AW      = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic                 cfg_sel,
  input  logic [7:0]           cfg_wdata,
  input  logic                 wr_valid,
  output logic                 wr_ready,
  input  logic [AW-1:0]        wr_addr,
  input  logic [7:0]           wr_data,
  output logic                 mem_re,
  output logic [NPLANES-1:0]   mem_we,
  output logic [AW-1:0]        mem_addr,
  output logic [8*NPLANES-1:0] mem_wdata,
  input  logic [8*NPLANES-1:0] mem_rdata
);
  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE} st_t;

  st_t               st;
  logic [1:0]        pg_q;
  logic              dir_q;
  logic [7:0]        ci_q;
  logic              dir_l;
  logic [7:0]        ci_l;
  logic [7:0]        data_l;
  logic [AW-1:0]     addr_l;
  logic [31:0]       pmask;
  logic              accept;

  assign accept   = wr_valid && (st == S_IDLE);
  assign wr_ready = (st == S_IDLE);
  assign pmask    = (32'd1 << (32'd13 + 32'(pg_q))) - 32'd1;
  assign mem_re   = (st == S_READ);
  assign mem_addr = addr_l;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pg_q  <= '0;
      dir_q <= 1'b0;
      ci_q  <= '0;
    end else if (cfg_we) begin
      if (cfg_sel) ci_q <= cfg_wdata;
      else begin
        pg_q  <= cfg_wdata[1:0];
        dir_q <= cfg_wdata[4];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      dir_l  <= 1'b0;
      ci_l   <= '0;
      data_l <= '0;
      addr_l <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          dir_l  <= dir_q;
          ci_l   <= ci_q;
          data_l <= wr_data;
          addr_l <= wr_addr & pmask[AW-1:0];
          st     <= dir_q ? S_WRITE : S_READ;
        end
        S_READ:  st <= S_WRITE;
        default: st <= S_IDLE;
      endcase
    end
  end

  for (genvar p = 0; p < NPLANES; p++) begin : g_plane
    logic [7:0] old_b, fill_b;
    assign old_b  = mem_rdata[8*p +: 8];
    assign fill_b = (old_b & ~data_l) | (data_l & {8{ci_l[p]}});
    assign mem_wdata[8*p +: 8] = dir_l ? data_l : fill_b;
    assign mem_we[p] = (st == S_WRITE) && (!dir_l || ci_l[p]);
  end
endmodule

// File: rtl/planar_wr_unit_chk.sv
module planar_wr_unit_chk #(
  parameter int NPLANES = 8,
  parameter int AW      = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_valid,
  input logic               wr_ready,
  input logic               mem_re,
  input logic [NPLANES-1:0] mem_we,
  input logic [AW-1:0]      mem_addr
);
  a_r5_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !wr_ready);
  a_r5_ready_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (|mem_we) |=> wr_ready);
  a_r2_read_then_full_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> (&mem_we));
  a_r2_same_address: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> (mem_addr == $past(mem_addr)));
  a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && (|mem_we)));
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (!mem_re && mem_we == '0));
endmodule

bind planar_wr_unit planar_wr_unit_chk #(.NPLANES(NPLANES), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr));

// File: tb/tb_planar_wr_unit.sv
module tb_planar_wr_unit;
  localparam int NP = 8;
  localparam int AW = 16;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_sel = 0;
  logic [7:0] cfg_wdata = 0;
  logic wr_valid = 0, wr_ready;
  logic [AW-1:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic mem_re;
  logic [NP-1:0] mem_we;
  logic [AW-1:0] mem_addr;
  logic [8*NP-1:0] mem_wdata, mem_rdata;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  planar_wr_unit #(.NPLANES(NP), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .mem_re(mem_re), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  logic [63:0] mem [int unsigned];

  function automatic logic [63:0] rd(int unsigned a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  always @(posedge clk) begin
    logic [63:0] w;
    if (mem_re) mem_rdata <= rd(mem_addr);
    if (|mem_we) begin
      w = rd(mem_addr);
      for (int p = 0; p < NP; p++) if (mem_we[p]) w[8*p +: 8] = mem_wdata[8*p +: 8];
      mem[mem_addr] = w;
    end
  end

  // mode, ci, addr, data, init, expected
  localparam logic [167:0] VECS [0:6] = '{
    {8'h00, 8'h05, 16'h0010, 8'hF0, 64'h0, 64'h0000_0000_00F0_00F0},
    {8'h00, 8'h00, 16'h0020, 8'h0F, 64'hFFFF_FFFF_FFFF_FFFF, 64'hF0F0_F0F0_F0F0_F0F0},
    {8'h00, 8'hFF, 16'h0028, 8'h00, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF},
    {8'h10, 8'h81, 16'h0030, 8'h5A, 64'h1111_1111_1111_1111, 64'h5A11_1111_1111_115A},
    {8'h10, 8'h00, 16'h0038, 8'hFF, 64'h2222_2222_2222_2222, 64'h2222_2222_2222_2222},
    {8'h10, 8'hFF, 16'h0040, 8'h3C, 64'h0, 64'h3C3C_3C3C_3C3C_3C3C},
    {8'h00, 8'hA5, 16'h0048, 8'h81, 64'h4242_4242_4242_4242, 64'hC342_C342_42C3_42C3}
  };

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg(logic sel, logic [7:0] v);
    @(negedge clk); cfg_we = 1; cfg_sel = sel; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic cpu_wr(logic [AW-1:0] a, logic [7:0] d, output int busy);
    @(negedge clk); wr_valid = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_valid = 0; busy = 0;
    while (!wr_ready) begin busy++; @(negedge clk); end
  endtask

  initial begin
    int busy;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 ready", {63'h0, wr_ready}, 64'h1);
    check("R1 idle mem", {55'h0, mem_re, mem_we}, 64'h0);

    // R1: defaults give transparent colour 0 -> clears painted pixels
    mem[16'h0100] = 64'hFFFF_FFFF_FFFF_FFFF;
    cpu_wr(16'h0100, 8'hFF, busy);
    check("R1 default clear", mem[16'h0100], 64'h0);

    for (int i = 0; i < 7; i++) begin
      logic [167:0] v;
      v = VECS[i];
      cfg(1'b0, v[167:160]);
      cfg(1'b1, v[159:152]);
      mem[v[151:136]] = v[127:64];
      cpu_wr(v[151:136], v[135:128], busy);
      check(v[164] ? "R3/R8 direct vector" : "R2/R7 transparent vector",
            mem[v[151:136]], v[63:0]);
      check("R5 busy cycles", busy, v[164] ? 1 : 2);
    end

    // R4 page masking, direct mask plane 0
    cfg(1'b1, 8'h01);
    for (int dm = 1; dm < 4; dm++) begin
      int unsigned tgt;
      tgt = 32'hC123 & ((32'd1 << (13 + dm)) - 1);
      mem[16'hC123] = 64'h0;
      mem[tgt] = 64'h0;
      cfg(1'b0, 8'h10 | 8'(dm));
      cpu_wr(16'hC123, 8'hAA, busy);
      check($sformatf("R4 page %0d target", dm), {56'h0, mem[tgt][7:0]}, 64'hAA);
      if (tgt != 32'hC123)
        check($sformatf("R4 page %0d alias untouched", dm), mem[16'hC123], 64'h0);
    end
    cfg(1'b0, 8'h00);
    mem[16'hE010] = 64'h0;
    mem[16'h0010] = 64'h0;
    cpu_wr(16'hE010, 8'h01, busy);
    check("R4 page 0 target", mem[16'h0010], 64'h0000_0000_0000_0001);

    // R6 colour change while busy uses captured colour
    cfg(1'b1, 8'h03);
    mem[16'h0200] = 64'h0;
    @(negedge clk); wr_valid = 1; wr_addr = 16'h0200; wr_data = 8'h0F;
    @(negedge clk); wr_valid = 0; cfg_we = 1; cfg_sel = 1; cfg_wdata = 8'hFC;
    @(negedge clk); cfg_we = 0;
    while (!wr_ready) @(negedge clk);
    check("R6 captured colour", mem[16'h0200], 64'h0000_0000_0000_0F0F);
    mem[16'h0208] = 64'h0;
    cpu_wr(16'h0208, 8'h0F, busy);
    check("R6 new colour later", mem[16'h0208], 64'h0F0F_0F0F_0F0F_0000);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule